// File: doc/BRIEF.md
# Integer ALU with Carry, Overflow and Zero Flags

This block is a combinational integer arithmetic-logic unit for the execute stage of a simple load-store processor. It has no clock and no state. It takes two operands, a shift amount and a 4-bit operation code. Within the same cycle it returns a result, a carry-out flag, a signed-overflow flag and a zero flag. The datapath width is a parameter and defaults to 32 bits.

Subtraction reuses the adder. The second operand is inverted and the carry-in is forced high. Both set-less-than operations read their answer from that same subtraction. The signed compare takes the true sign of the difference, so it stays correct when the subtraction overflows. The unsigned compare uses the borrow. Shifts always act on the first operand, and only the low log2(W) bits of the shift-amount input are used.

Top module: `int_alu`

## Requirements
- R1: Operation code 0 (add) returns a+b modulo 2^W. The carry flag equals the carry out of the most significant bit.
- R2: Operation code 1 (subtract) returns a-b modulo 2^W, computed as a + ~b + 1. The carry flag is 1 exactly when a >= b unsigned, meaning no borrow.
- R3: On add, the overflow flag is 1 when a and b have the same sign and the result's sign differs from it. On subtract, it is 1 when a and b have different signs and the result's sign differs from the sign of a. Otherwise it is 0.
- R4: Codes 2, 3, 4 and 5 return a AND b, a OR b, a XOR b and NOT(a OR b), bit by bit.
- R5: Code 6 (signed set-less-than) returns 1 when a < b in two's complement, else 0. The answer is correct even when a-b overflows, for example a = 0x80000000 and b = 1. All upper bits are 0.
- R6: Code 7 (unsigned set-less-than) returns 1 when a < b as unsigned numbers, else 0.
- R7: Code 8 shifts a left and code 9 shifts a right. Both are logical shifts, and vacated bits are filled with 0.
- R8: Code 10 shifts a right arithmetically, filling vacated high bits with copies of a[W-1].
- R9: Only the low log2(W) bits of the shift amount are used. Any higher bits are ignored, so an amount of 33 shifts by 1 when W is 32.
- R10: The zero flag is 1 exactly when every result bit is 0, for every operation code.
- R11: For codes 2 to 10, the carry and overflow flags are 0.
- R12: Codes 11 to 15 are undefined. They return a zero result, with carry and overflow both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | W | First operand, and the value that is shifted |
| b_in | input | W | Second operand |
| shamt | input | SAW | Shift amount; only the low log2(W) bits are used |
| op | input | 4 | Operation code |
| result | output | W | Operation result |
| carry | output | 1 | Carry out of the MSB (add and subtract only) |
| ovf | output | 1 | Signed overflow (add and subtract only) |
| zero | output | 1 | Result is all zeros |

## Verification
Carry-out and signed overflow can both be raised by a single addition, and in that same cycle the zero flag can rise too. The bench provokes this by adding 0x80000000 to itself, which should give carry 1, overflow 1 and zero 1 together. It also subtracts a negative number from a positive one, which should set overflow while carry is 0. In both cases the bench judges each flag on its own against a reference model written in wide integers. A second overlap is the signed compare of 0x80000000 against 1. There the internal subtraction overflows in the same cycle as the compare, and the expected answer is 1 whatever the sign bit of the difference.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int W   = 32,
  parameter int SAW = 8
) (
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   b_in,
  input  logic [SAW-1:0] shamt,
  input  logic [3:0]     op,
  output logic [W-1:0]   result,
  output logic           carry,
  output logic           ovf,
  output logic           zero
);
  localparam int SW = $clog2(W);
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_AND = 4'd2,
                         OP_OR  = 4'd3, OP_XOR = 4'd4, OP_NOR = 4'd5,
                         OP_SLT = 4'd6, OP_SLTU = 4'd7, OP_SLL = 4'd8,
                         OP_SRL = 4'd9, OP_SRA = 4'd10;

  logic          negate;
  logic [W-1:0]  b_eff;
  logic [W:0]    sum;
  logic          v_raw;
  logic          arith;
  logic [SW-1:0] sh;

  assign negate = (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);
  assign b_eff  = negate ? ~b_in : b_in;
  assign sum    = {1'b0, a_in} + {1'b0, b_eff} + {{W{1'b0}}, negate};
  assign v_raw  = (a_in[W-1] == b_eff[W-1]) && (sum[W-1] != a_in[W-1]);
  assign arith  = (op == OP_ADD) || (op == OP_SUB);
  assign sh     = shamt[SW-1:0];

  always_comb begin
    case (op)
      OP_ADD, OP_SUB: result = sum[W-1:0];
      OP_AND:  result = a_in & b_in;
      OP_OR:   result = a_in | b_in;
      OP_XOR:  result = a_in ^ b_in;
      OP_NOR:  result = ~(a_in | b_in);
      OP_SLT:  result = {{(W-1){1'b0}}, sum[W-1] ^ v_raw};
      OP_SLTU: result = {{(W-1){1'b0}}, ~sum[W]};
      OP_SLL:  result = a_in << sh;
      OP_SRL:  result = a_in >> sh;
      OP_SRA:  result = W'($signed(a_in) >>> sh);
      default: result = '0;
    endcase
  end

  assign carry = arith & sum[W];
  assign ovf   = arith & v_raw;
  assign zero  = ~|result;
endmodule

module int_alu_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [3:0]   op,
  input logic [W-1:0] result,
  input logic         carry,
  input logic         ovf,
  input logic         zero
);
  always_comb begin
    if (!$isunknown({a_in, b_in, op, result, carry, ovf, zero})) begin
      a_r10_zero_flag: assert (zero == (result == '0));
      if (op >= 4'd2)
        a_r11_flags_clear: assert (!carry && !ovf);
      if (op >= 4'd11)
        a_r12_undef_zero: assert (result == '0 && zero);
      if (op == 4'd6 || op == 4'd7)
        a_r5_slt_single_bit: assert (result[W-1:1] == '0);
      if (op == 4'd0)
        a_r3_add_ovf: assert (ovf == ((a_in[W-1] == b_in[W-1]) && (result[W-1] != a_in[W-1])));
      if (op == 4'd1)
        a_r3_sub_ovf: assert (ovf == ((a_in[W-1] != b_in[W-1]) && (result[W-1] != a_in[W-1])));
    end
  end
endmodule

bind int_alu int_alu_chk #(.W(W)) u_chk (
  .a_in(a_in), .b_in(b_in), .op(op), .result(result),
  .carry(carry), .ovf(ovf), .zero(zero)
);

// File: tb/int_alu_tb.sv
module int_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a_in, b_in, result;
  logic [7:0]  shamt;
  logic [3:0]  op;
  logic        carry, ovf, zero;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  int_alu #(.W(32), .SAW(8)) u_dut (
    .a_in(a_in), .b_in(b_in), .shamt(shamt), .op(op),
    .result(result), .carry(carry), .ovf(ovf), .zero(zero)
  );

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4, 4'd5: return "R4";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd8, 4'd9: return "R7";
      4'd10: return "R8";
      default: return "R12";
    endcase
  endfunction

  task automatic apply(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [7:0] s);
    longint ua, ub, full;
    int     k;
    logic [31:0] er;
    logic        ec, ev;
    @(posedge clk);
    op = o; a_in = a; b_in = b; shamt = s;
    ua = longint'(a); ub = longint'(b); k = int'(s % 32);
    ec = 1'b0; ev = 1'b0; er = '0;
    case (o)
      4'd0: begin full = ua + ub; er = full[31:0]; ec = full[32];
                  ev = (a[31] == b[31]) && (er[31] != a[31]); end
      4'd1: begin full = ua - ub; er = full[31:0]; ec = (ua >= ub);
                  ev = (a[31] != b[31]) && (er[31] != a[31]); end
      4'd2: er = a & b;
      4'd3: er = a | b;
      4'd4: er = a ^ b;
      4'd5: er = ~(a | b);
      4'd6: er = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'd7: er = (ua < ub) ? 32'd1 : 32'd0;
      4'd8: begin er = a; for (int i = 0; i < k; i++) er = {er[30:0], 1'b0}; end
      4'd9: begin er = a; for (int i = 0; i < k; i++) er = {1'b0, er[31:1]}; end
      4'd10: begin er = a; for (int i = 0; i < k; i++) er = {a[31], er[31:1]}; end
      default: er = '0;
    endcase
    @(negedge clk);
    n_cmp++;
    // R10 zero flag and R11 flag clearing are compared on every vector
    if (result !== er || carry !== ec || ovf !== ev || zero !== (er == 0)) begin
      n_bad++;
      $display("FAIL %s/R10/R11 op=%0d a=%h b=%h s=%0d: got r=%h c=%b v=%b z=%b exp r=%h c=%b v=%b z=%b",
               req_of(o), o, a, b, s, result, carry, ovf, zero, er, ec, ev, er == 0);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    op = 4'd0; a_in = '0; b_in = '0; shamt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (result !== 0 || carry !== 0 || ovf !== 0 || zero !== 1) begin
      n_bad++;
      $display("FAIL R10 reset idle: r=%h c=%b v=%b z=%b exp 0 0 0 1", result, carry, ovf, zero);
    end
    rst_n = 1'b1;
    apply(4'd0, 32'h8000_0000, 32'h8000_0000, 0); // R3 carry, overflow and zero together
    apply(4'd0, 32'h7fff_ffff, 32'h0000_0001, 0); // R3 positive overflow
    apply(4'd0, 32'hffff_ff73, 32'h0000_00a9, 0); // R1 carry without overflow
    apply(4'd1, 32'h0000_0000, 32'h0000_0001, 0); // R2 borrow
    apply(4'd1, 32'h7fff_ffff, 32'hffff_ffff, 0); // R3 sub overflow
    apply(4'd1, 32'h8000_0000, 32'h0000_0001, 0); // R3 sub overflow negative
    apply(4'd1, 32'h1234_5678, 32'h1234_5678, 0); // R10 zero after subtract
    apply(4'd6, 32'h8000_0000, 32'h0000_0001, 0); // R5 overflowing compare
    apply(4'd6, 32'h7fff_ffff, 32'h8000_0000, 0);
    apply(4'd6, 32'hffff_fffe, 32'hffff_ffff, 0);
    apply(4'd7, 32'h0000_0001, 32'hffff_ffff, 0); // R6
    apply(4'd7, 32'hffff_ffff, 32'h0000_0001, 0);
    apply(4'd10, 32'h8000_0000, 32'h0, 31);       // R8
    apply(4'd10, 32'hffff_fff5, 32'h0, 2);
    apply(4'd9, 32'hffff_fff5, 32'h0, 2);         // R7
    apply(4'd8, 32'hffff_fff9, 32'h0, 2);
    apply(4'd8, 32'h0000_0003, 32'h0, 8'd33);     // R9 high bits ignored
    apply(4'd9, 32'h8000_0000, 32'h0, 8'hff);     // R9
    apply(4'd5, 32'h0, 32'h0, 0);
    apply(4'd2, 32'hf0f0_f0f0, 32'h0f0f_0f0f, 0); // R10 zero from AND
    for (int o = 11; o < 16; o++) apply(4'(o), 32'hdead_beef, 32'h1234_5678, 3); // R12
    for (int i = 0; i < 600; i++)
      apply(4'($urandom_range(0, 15)), $urandom, $urandom, 8'($urandom));
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule